// File: doc/BRIEF.md
# Pipelined Signed Complex Multiplier

The block multiplies two signed complex operands, `a = a_re + j*a_im` and `b = b_re + j*b_im`. It delivers the real and imaginary parts of either `a*b` or `a*conj(b)`. A build-time parameter picks between the two. Four multipliers are inferred from plain RTL. Their products feed a subtract for the real part and an add for the imaginary part.

The data flows through four register groups, in this order: operand capture, product, sum and result. The depth of each group is a separate parameter. A depth of zero turns that group into a wire. One clock enable freezes the whole chain, and an asynchronous active-low reset clears it.

Internal arithmetic is held at twice the operand width. The single input that does not fit is all four operands at the most negative value, and its imaginary part wraps. This input is taken as never occurring in practice. Results are then sign-extended or truncated to the output width.

Top module: `cplx_mult`

## Requirements
- R1: `p_re` equals `a_re*b_re - a_im*b_im`, computed on signed operands of width `IN_W` and wrapped to `2*IN_W` bits before resizing.
- R2: `p_im` equals `a_re*b_im + a_im*b_re`, computed on signed operands of width `IN_W` and wrapped to `2*IN_W` bits before resizing.
- R3: With `CONJ_B = 1`, `b_im` is replaced by its two's-complement negation wrapped to `IN_W` bits, so the result is `a*conj(b)`. The most negative `b_im` therefore stays unchanged.
- R4: A result is due after exactly `D_IN + D_PROD + D_SUM + D_OUT` rising clock edges at which `ce` is high. A stage of depth 0 adds no register.
- R5: While `ce` is low, no register advances, so `p_re` and `p_im` hold their values (when the total latency is at least 1).
- R6: While `rst_n` is low, every pipeline register is zero, and `p_re` and `p_im` read 0 without waiting for a clock edge.
- R7: If `OUT_W >= 2*IN_W`, the wrapped result is sign-extended to `OUT_W`. Otherwise its low `OUT_W` bits are kept.
- R8: With all four operands at the most negative value, `p_im` is the wrapped value `-2^(2*IN_W-1)` (for 3-bit inputs: 32 wraps to -32) and `p_re` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce | input | 1 | Clock enable for every pipeline register |
| a_re | input | IN_W | Real part of operand a, signed |
| a_im | input | IN_W | Imaginary part of operand a, signed |
| b_re | input | IN_W | Real part of operand b, signed |
| b_im | input | IN_W | Imaginary part of operand b, signed |
| p_re | output | OUT_W | Real part of the result, signed |
| p_im | output | OUT_W | Imaginary part of the result, signed |

## Verification
Both results are due three enabled edges after their operands are applied. This holds for every configuration on the bench, including one that places all of its registers in the first two stages. The bench keeps a history of the operands applied at each enabled edge, three entries deep. It shifts this history only on edges where `ce` was high, and it clears the history when reset is asserted. On the falling edge after every cycle, it compares both outputs of each instance with the reference computed from the oldest entry. Stalled cycles therefore expect unchanged outputs, and the first cycles after a reset expect zero.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  // Total register count through the four stages
  function automatic int unsigned cmul_latency(int unsigned d_in, int unsigned d_prod,
                                               int unsigned d_sum, int unsigned d_out);
    return d_in + d_prod + d_sum + d_out;
  endfunction

endpackage

// File: rtl/cmul_pipe.sv
module cmul_pipe #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (DEPTH == 0) begin : g_bypass
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_n, ce};
      assign dout = din;
    end else begin : g_regs
      logic [DEPTH-1:0][W-1:0] stage_q;
      logic [DEPTH-1:0][W-1:0] stage_d;

      always_comb begin
        for (int i = 0; i < int'(DEPTH); i++) begin
          if (ce) begin
            stage_d[i] = (i == 0) ? din : stage_q[(i == 0) ? 0 : i-1];
          end else begin
            stage_d[i] = stage_q[i];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= '0;
        end else begin
          stage_q <= stage_d;
        end
      end

      assign dout = stage_q[DEPTH-1];

      AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(stage_q)); // R5
      AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> stage_q[0] == $past(din)); // R4
    end
  endgenerate

endmodule

// File: rtl/cmul_product.sv
module cmul_product #(
  parameter int unsigned IN_W = 18,
  localparam int unsigned PW  = 2 * IN_W
) (
  input  logic [IN_W-1:0] op_ar,
  input  logic [IN_W-1:0] op_ai,
  input  logic [IN_W-1:0] op_br,
  input  logic [IN_W-1:0] op_bi,
  output logic [PW-1:0]   m_rr,
  output logic [PW-1:0]   m_ii,
  output logic [PW-1:0]   m_ri,
  output logic [PW-1:0]   m_ir
);

  logic signed [PW-1:0] s_rr, s_ii, s_ri, s_ir;

  // Signed IN_W x IN_W always fits in 2*IN_W bits
  always_comb begin
    s_rr = PW'($signed(op_ar)) * PW'($signed(op_br));
    s_ii = PW'($signed(op_ai)) * PW'($signed(op_bi));
    s_ri = PW'($signed(op_ar)) * PW'($signed(op_bi));
    s_ir = PW'($signed(op_ai)) * PW'($signed(op_br));
  end

  assign m_rr = s_rr;
  assign m_ii = s_ii;
  assign m_ri = s_ri;
  assign m_ir = s_ir;

endmodule

// File: rtl/cmul_sum.sv
module cmul_sum #(
  parameter int unsigned PW = 36
) (
  input  logic [PW-1:0] m_rr,
  input  logic [PW-1:0] m_ii,
  input  logic [PW-1:0] m_ri,
  input  logic [PW-1:0] m_ir,
  output logic [PW-1:0] s_re,
  output logic [PW-1:0] s_im
);

  localparam logic [PW-1:0] MIN_SQ   = {2'b01, {(PW-2){1'b0}}};
  localparam logic [PW-1:0] WRAP_MIN = {1'b1, {(PW-1){1'b0}}};

  // No carry bit: sums wrap at PW bits
  always_comb begin
    s_re = m_rr - m_ii;
    s_im = m_ri + m_ir;
  end

  always_comb begin
    if (m_ri == MIN_SQ && m_ir == MIN_SQ) begin
      AST_CORNER_WRAP: assert (s_im == WRAP_MIN); // R8
    end
  end

endmodule

// File: rtl/cmul_resize.sv
module cmul_resize #(
  parameter int unsigned PW    = 36,
  parameter int unsigned OUT_W = 36
) (
  input  logic [PW-1:0]    din,
  output logic [OUT_W-1:0] dout
);

  generate
    if (OUT_W > PW) begin : g_extend
      assign dout = {{(OUT_W-PW){din[PW-1]}}, din};
    end else if (OUT_W == PW) begin : g_same
      assign dout = din;
    end else begin : g_trunc
      logic [PW-OUT_W-1:0] unused_hi;
      assign unused_hi = din[PW-1:OUT_W];
      assign dout = din[OUT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/cplx_mult.sv
module cplx_mult #(
  parameter int unsigned IN_W   = 18,
  parameter int unsigned OUT_W  = 36,
  parameter bit          CONJ_B = 1'b0,
  parameter int unsigned D_IN   = 1,
  parameter int unsigned D_PROD = 0,
  parameter int unsigned D_SUM  = 1,
  parameter int unsigned D_OUT  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [IN_W-1:0]  a_re,
  input  logic [IN_W-1:0]  a_im,
  input  logic [IN_W-1:0]  b_re,
  input  logic [IN_W-1:0]  b_im,
  output logic [OUT_W-1:0] p_re,
  output logic [OUT_W-1:0] p_im
);

  import cmul_pkg::*;

  localparam int unsigned PW  = 2 * IN_W;
  localparam int unsigned LAT = cmul_latency(D_IN, D_PROD, D_SUM, D_OUT);

  logic [IN_W-1:0] bi_eff;

  generate
    if (CONJ_B) begin : g_conj
      assign bi_eff = (~b_im) + 1'b1;   // wraps at IN_W: min stays min
    end else begin : g_plain
      assign bi_eff = b_im;
    end
  endgenerate

  // Operand stage
  logic [4*IN_W-1:0] op_d, op_q;
  assign op_d = {a_re, a_im, b_re, bi_eff};

  cmul_pipe #(.W(4*IN_W), .DEPTH(D_IN)) u_op_pipe (
    .clk(clk), .rst_n(rst_n), .ce(ce), .din(op_d), .dout(op_q)
  );

  // Product stage
  logic [PW-1:0] m_rr, m_ii, m_ri, m_ir;

  cmul_product #(.IN_W(IN_W)) u_product (
    .op_ar(op_q[4*IN_W-1:3*IN_W]),
    .op_ai(op_q[3*IN_W-1:2*IN_W]),
    .op_br(op_q[2*IN_W-1:IN_W]),
    .op_bi(op_q[IN_W-1:0]),
    .m_rr(m_rr), .m_ii(m_ii), .m_ri(m_ri), .m_ir(m_ir)
  );

  logic [4*PW-1:0] prod_q;

  cmul_pipe #(.W(4*PW), .DEPTH(D_PROD)) u_prod_pipe (
    .clk(clk), .rst_n(rst_n), .ce(ce), .din({m_rr, m_ii, m_ri, m_ir}), .dout(prod_q)
  );

  // Sum stage
  logic [PW-1:0] s_re, s_im;

  cmul_sum #(.PW(PW)) u_sum (
    .m_rr(prod_q[4*PW-1:3*PW]),
    .m_ii(prod_q[3*PW-1:2*PW]),
    .m_ri(prod_q[2*PW-1:PW]),
    .m_ir(prod_q[PW-1:0]),
    .s_re(s_re), .s_im(s_im)
  );

  logic [2*PW-1:0] sum_q;

  cmul_pipe #(.W(2*PW), .DEPTH(D_SUM)) u_sum_pipe (
    .clk(clk), .rst_n(rst_n), .ce(ce), .din({s_re, s_im}), .dout(sum_q)
  );

  // Resize and output stage
  logic [OUT_W-1:0] r_re, r_im;

  cmul_resize #(.PW(PW), .OUT_W(OUT_W)) u_rs_re (.din(sum_q[2*PW-1:PW]), .dout(r_re));
  cmul_resize #(.PW(PW), .OUT_W(OUT_W)) u_rs_im (.din(sum_q[PW-1:0]),    .dout(r_im));

  logic [2*OUT_W-1:0] out_q;

  cmul_pipe #(.W(2*OUT_W), .DEPTH(D_OUT)) u_out_pipe (
    .clk(clk), .rst_n(rst_n), .ce(ce), .din({r_re, r_im}), .dout(out_q)
  );

  assign p_re = out_q[2*OUT_W-1:OUT_W];
  assign p_im = out_q[OUT_W-1:0];

  generate
    if (LAT > 0) begin : g_hold_chk
      AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(p_re) && $stable(p_im))); // R5
    end
  endgenerate

endmodule

// File: tb/cplx_mult_test.sv
module cplx_mult_test;

  localparam int LAT = 3;
  localparam int NI  = 5;

  // instance table: width index, conjugate, output width
  localparam int WIDX [NI] = '{0, 0, 1, 1, 2};
  localparam int CONJ [NI] = '{0, 1, 0, 1, 0};
  localparam int OUTW [NI] = '{36, 36, 54, 40, 8};
  localparam int WVAL [3]  = '{18, 27, 3};

  logic clk = 1'b0;
  logic rst_n;
  logic ce;
  always #5 clk = ~clk;

  logic [17:0] x18 [4];
  logic [26:0] x27 [4];
  logic [2:0]  x3  [4];

  logic [35:0] re0, im0, re1, im1;
  logic [53:0] re2, im2;
  logic [39:0] re3, im3;
  logic [7:0]  re4, im4;

  cplx_mult uut (.clk(clk), .rst_n(rst_n), .ce(ce),
    .a_re(x18[0]), .a_im(x18[1]), .b_re(x18[2]), .b_im(x18[3]), .p_re(re0), .p_im(im0));
  cplx_mult #(.IN_W(18), .OUT_W(36), .CONJ_B(1'b1)) uut_c18 (.clk(clk), .rst_n(rst_n), .ce(ce),
    .a_re(x18[0]), .a_im(x18[1]), .b_re(x18[2]), .b_im(x18[3]), .p_re(re1), .p_im(im1));
  cplx_mult #(.IN_W(27), .OUT_W(54), .CONJ_B(1'b0)) uut_w27 (.clk(clk), .rst_n(rst_n), .ce(ce),
    .a_re(x27[0]), .a_im(x27[1]), .b_re(x27[2]), .b_im(x27[3]), .p_re(re2), .p_im(im2));
  cplx_mult #(.IN_W(27), .OUT_W(40), .CONJ_B(1'b1)) uut_c27 (.clk(clk), .rst_n(rst_n), .ce(ce),
    .a_re(x27[0]), .a_im(x27[1]), .b_re(x27[2]), .b_im(x27[3]), .p_re(re3), .p_im(im3));
  cplx_mult #(.IN_W(3), .OUT_W(8), .CONJ_B(1'b0), .D_IN(2), .D_PROD(1), .D_SUM(0), .D_OUT(0))
    uut_n3 (.clk(clk), .rst_n(rst_n), .ce(ce),
    .a_re(x3[0]), .a_im(x3[1]), .b_re(x3[2]), .b_im(x3[3]), .p_re(re4), .p_im(im4));

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  string phase = "";

  longint cur  [3][4];
  longint hist [LAT][3][4];

  function automatic longint sx(longint v, int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  function automatic longint ref_val(longint ar, longint ai, longint br, longint bi,
                                     int w, int conj, int outw, bit imag);
    longint b, v;
    b = conj ? sx(-bi, w) : bi;
    v = imag ? (ar * b + ai * br) : (ar * br - ai * b);
    v = sx(v, 2 * w);
    if (outw < 2 * w) v = sx(v, outw);
    return v;
  endfunction

  function automatic longint got_val(int k, bit imag);
    case (k)
      0: return imag ? longint'($signed(im0)) : longint'($signed(re0));
      1: return imag ? longint'($signed(im1)) : longint'($signed(re1));
      2: return imag ? longint'($signed(im2)) : longint'($signed(re2));
      3: return imag ? longint'($signed(im3)) : longint'($signed(re3));
      default: return imag ? longint'($signed(im4)) : longint'($signed(re4));
    endcase
  endfunction

  function automatic string inst_tag(int k);
    case (k)
      1: return "R3";
      3: return "R3 R7";
      4: return "R7";
      default: return "";
    endcase
  endfunction

  task automatic drive_ports();
    for (int i = 0; i < 4; i++) begin
      x18[i] = 18'(cur[0][i]);
      x27[i] = 27'(cur[1][i]);
      x3[i]  = 3'(cur[2][i]);
    end
  endtask

  task automatic clear_hist();
    for (int d = 0; d < LAT; d++)
      for (int g = 0; g < 3; g++)
        for (int i = 0; i < 4; i++) hist[d][g][i] = 0;
  endtask

  task automatic check_all();
    for (int k = 0; k < NI; k++) begin
      for (int p = 0; p < 2; p++) begin
        longint e, g;
        int wi;
        wi = WIDX[k];
        e = ref_val(hist[LAT-1][wi][0], hist[LAT-1][wi][1], hist[LAT-1][wi][2],
                    hist[LAT-1][wi][3], WVAL[wi], CONJ[k], OUTW[k], p[0]);
        g = got_val(k, p[0]);
        n_vec++;
        if (g !== e) begin
          n_bad++;
          $display("FAIL %s %s %s inst%0d: actual %0d expected %0d", phase,
                   p ? "im R2" : "re R1", inst_tag(k), k, g, e);
        end
      end
    end
  endtask

  task automatic step(bit ce_v);
    ce = ce_v;
    drive_ports();
    @(posedge clk);
    #1;
    if (ce_v) begin
      for (int d = LAT - 1; d > 0; d--) hist[d] = hist[d-1];
      hist[0] = cur;
    end
    @(negedge clk);
    check_all();
  endtask

  function automatic longint corner(int kind, int w);
    case (kind)
      0: return 0;
      1: return 1;
      2: return -1;
      3: return (longint'(1) <<< (w - 1)) - 1;
      default: return -(longint'(1) <<< (w - 1));
    endcase
  endfunction

  task automatic set_random();
    for (int i = 0; i < 4; i++) begin
      longint r;
      r = longint'({$urandom, $urandom});
      cur[0][i] = sx(r, 18);
      cur[1][i] = sx(r >>> 5, 27);
      cur[2][i] = sx(r >>> 11, 3);
    end
  endtask

  task automatic set_zero();
    for (int g = 0; g < 3; g++)
      for (int i = 0; i < 4; i++) cur[g][i] = 0;
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0;
    ce    = 1'b0;
    set_zero();
    drive_ports();
    clear_hist();

    // R6: reset state
    phase = "R6 reset";
    repeat (3) @(negedge clk);
    check_all();
    rst_n = 1'b1;

    // R4: single impulse, then zeros
    phase = "R4 latency";
    set_random();
    step(1'b1);
    set_zero();
    repeat (5) step(1'b1);

    // R8 and directed corners, R3 covers min negation
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++)
          for (int d = 0; d < 5; d++) begin
            int kd [4];
            kd = '{a, b, c, d};
            phase = (a == 4 && b == 4 && c == 4 && d == 4) ? "R8 all-min" : "corner";
            for (int g = 0; g < 3; g++)
              for (int i = 0; i < 4; i++) cur[g][i] = corner(kd[i], WVAL[g]);
            step(1'b1);
          end

    phase = "random";
    repeat (2000) begin
      set_random();
      step(1'b1);
    end

    // R5: stalls via toggling clock enable
    phase = "R5 stall";
    repeat (2000) begin
      set_random();
      step(($urandom % 10) < 6);
    end

    // R6: asynchronous reset in mid stream
    phase = "R6 mid-reset";
    ce = 1'b1;
    rst_n = 1'b0;
    #1;
    clear_hist();
    check_all();
    repeat (2) @(negedge clk);
    check_all();
    rst_n = 1'b1;

    phase = "after reset";
    repeat (200) begin
      set_random();
      step(($urandom % 4) != 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule